// File: doc/BRIEF.md
# Inbound Message Slot Queue with Held Acknowledge

This block sits at the receiving end of a broadcast messaging network. Each arriving message has a 128-bit header and a 128-bit payload, offered on a valid/ready handshake. The block rearranges selected header and payload fields into a 256-bit (32-byte) queue entry and writes it through a write port into a 17-slot circular queue in memory. It then raises a one-cycle interrupt for that entry.

A message whose header asks for a software acknowledge takes one of eight acknowledge resources. The block picks the lowest-numbered free resource and puts its one-hot code into byte 15 of the entry. The resource stays held until software writes an acknowledge mask that names it. Software consumes queue entries in order by pulsing a pop input. The head and tail pointers are visible at the ports so software can find the oldest and newest entries.

Top module: `inbound_msg_queue`

## Requirements
- R1: After reset, head_ptr and tail_ptr are 0, qwr_en and irq are 0, res_busy is 0, and in_ready is 1.
- R2: Entry bits 95:0 equal payload bits 95:0. Entry bits 119:96 equal header bits 81:58, so the replied-to bit (header bit 58) lands in entry bit 96.
- R3: Entry bits 143:128 equal header bits 56:41. Entry bits 255:144 are zero.
- R4: When header bit 89 (acknowledge flag) is 1, entry bits 127:120 hold the one-hot code of the lowest-numbered free resource, and that resource becomes busy in res_busy. When the flag is 0, those bits are zero and no resource is taken.
- R5: One cycle after an accepted message, qwr_en is 1 for one cycle and qwr_addr equals the tail before acceptance. The tail then steps by one and wraps from 16 to 0.
- R6: irq pulses for one cycle together with each entry write. irq_both equals header bit 101 of that message.
- R7: With 17 entries held, in_ready is 0 and a valid message is not written. A pop makes room again.
- R8: With all eight resources busy, in_ready is 0 for a message with the acknowledge flag set. It stays 1 for a message with the flag clear.
- R9: An ack_wr pulse clears the busy bits named in ack_mask on the next cycle. Mask bits for free resources have no effect.
- R10: A pop while the queue is empty leaves head_ptr unchanged.
- R11: After a release, the next acknowledged message takes the lowest freed resource, even if higher-numbered resources were freed in the same mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Message can be taken this cycle |
| in_hdr | input | 128 | Message header |
| in_pay | input | 128 | Message payload |
| pop | input | 1 | Software consumed the oldest entry |
| ack_wr | input | 1 | Software acknowledge write strobe |
| ack_mask | input | 8 | Resources to release |
| qwr_en | output | 1 | Queue memory write enable |
| qwr_addr | output | 5 | Queue slot index written |
| qwr_data | output | 256 | Packed 32-byte entry |
| irq | output | 1 | One pulse per entry written |
| irq_both | output | 1 | Interrupt targets both sockets |
| head_ptr | output | 5 | Oldest occupied slot |
| tail_ptr | output | 5 | Next slot to write |
| res_busy | output | 8 | Acknowledge resources currently held |

## Verification
The hardest situation to reach from the ports is resource exhaustion with a partly full queue, where flow control depends on the header of the message being offered. The bench sends eight acknowledged messages, popping entries so the queue never fills. It then offers a ninth acknowledged message and checks that it is refused. Next it flips only the acknowledge flag and checks that the same offer is taken. A mixed release mask is then checked to make the next grant fall on the lowest freed resource. A separate pass fills the queue starting from a non-zero tail, so that pointer wrap and the full stall are both reached.

// File: rtl/imq_pkg.sv
package imq_pkg;
  localparam int HDR_W     = 128;
  localparam int PAY_W     = 128;
  localparam int ENTRY_W   = 256;
  localparam int VEC_W     = 8;
  // header bit positions decoded by this block
  localparam int H_ACKREQ  = 89;
  localparam int H_BOTH    = 101;
  localparam int H_A_LO    = 58;
  localparam int H_A_HI    = 81;
  localparam int H_B_LO    = 41;
  localparam int H_B_HI    = 56;
  // entry layout
  localparam int E_PAY_W   = 96;
  localparam int E_A_LSB   = 96;
  localparam int E_VEC_LSB = 120;
  localparam int E_B_LSB   = 128;
endpackage

// File: rtl/imq_pack.sv
module imq_pack
  import imq_pkg::*;
(
  input  logic [HDR_W-1:0]   hdr,
  input  logic [PAY_W-1:0]   pay,
  input  logic [VEC_W-1:0]   vec,
  output logic [ENTRY_W-1:0] entry
);
  localparam int A_W = H_A_HI - H_A_LO + 1;
  localparam int B_W = H_B_HI - H_B_LO + 1;

  always_comb begin
    entry = '0;
    entry[E_PAY_W-1:0]             = pay[E_PAY_W-1:0];
    entry[E_A_LSB +: A_W]          = hdr[H_A_HI:H_A_LO];
    entry[E_VEC_LSB +: VEC_W]      = vec;
    entry[E_B_LSB +: B_W]          = hdr[H_B_HI:H_B_LO];
  end
endmodule

// File: rtl/imq_respool.sv
module imq_respool #(
  parameter int NRES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic            rel_wr,
  input  logic [NRES-1:0] rel_mask,
  output logic [NRES-1:0] busy,
  output logic [NRES-1:0] grant,
  output logic            any_free
);
  logic [NRES-1:0] free_v;
  logic [NRES-1:0] busy_nx;

  assign free_v   = ~busy;
  assign grant    = free_v & (~free_v + NRES'(1));
  assign any_free = |free_v;

  always_comb begin
    busy_nx = busy;
    if (rel_wr)   busy_nx = busy_nx & ~rel_mask;
    if (alloc_en) busy_nx = busy_nx | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else        busy <= busy_nx;
  end
endmodule

// File: rtl/imq_ring.sv
module imq_ring #(
  parameter int DEPTH = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop_req,
  output logic [$clog2(DEPTH)-1:0]   head,
  output logic [$clog2(DEPTH)-1:0]   tail,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic             do_pop;
  logic [PTR_W-1:0] head_nx, tail_nx;
  logic [CNT_W-1:0] occ_nx;

  assign full   = (occ == CNT_W'(DEPTH));
  assign do_pop = pop_req && (occ != '0);

  always_comb begin
    head_nx = head;
    tail_nx = tail;
    occ_nx  = occ;
    if (push)   tail_nx = (tail == LAST) ? '0 : tail + PTR_W'(1);
    if (do_pop) head_nx = (head == LAST) ? '0 : head + PTR_W'(1);
    if (push && !do_pop)      occ_nx = occ + CNT_W'(1);
    else if (!push && do_pop) occ_nx = occ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= head_nx;
      tail <= tail_nx;
      occ  <= occ_nx;
    end
  end
endmodule

// File: rtl/inbound_msg_queue.sv
module inbound_msg_queue
  import imq_pkg::*;
#(
  parameter int DEPTH = 17,
  parameter int NRES  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [HDR_W-1:0]         in_hdr,
  input  logic [PAY_W-1:0]         in_pay,
  input  logic                     pop,
  input  logic                     ack_wr,
  input  logic [NRES-1:0]          ack_mask,
  output logic                     qwr_en,
  output logic [$clog2(DEPTH)-1:0] qwr_addr,
  output logic [ENTRY_W-1:0]       qwr_data,
  output logic                     irq,
  output logic                     irq_both,
  output logic [$clog2(DEPTH)-1:0] head_ptr,
  output logic [$clog2(DEPTH)-1:0] tail_ptr,
  output logic [NRES-1:0]          res_busy
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  logic             ack_req, accept, full, any_free;
  logic [NRES-1:0]  grant;
  logic [VEC_W-1:0] vec8;
  logic [ENTRY_W-1:0] entry;
  logic [CNT_W-1:0] occ;

  assign ack_req  = in_hdr[H_ACKREQ];
  assign in_ready = rst_q_n && !full && (!ack_req || any_free);
  assign accept   = in_valid && in_ready;

  always_comb begin
    vec8 = '0;
    if (ack_req) vec8[NRES-1:0] = grant;
  end

  imq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_q_n), .push(accept), .pop_req(pop),
    .head(head_ptr), .tail(tail_ptr), .occ(occ), .full(full)
  );

  imq_respool #(.NRES(NRES)) u_pool (
    .clk(clk), .rst_n(rst_q_n), .alloc_en(accept && ack_req),
    .rel_wr(ack_wr), .rel_mask(ack_mask), .busy(res_busy),
    .grant(grant), .any_free(any_free)
  );

  imq_pack u_pack (.hdr(in_hdr), .pay(in_pay), .vec(vec8), .entry(entry));

  // write port and interrupt: strobes every cycle, payload on enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      qwr_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      qwr_en <= accept;
      irq    <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      qwr_addr <= '0;
      qwr_data <= '0;
      irq_both <= 1'b0;
    end else if (accept) begin
      qwr_addr <= tail_ptr;
      qwr_data <= entry;
      irq_both <= in_hdr[H_BOTH];
    end
  end
endmodule

// File: rtl/imq_checker.sv
module imq_checker #(
  parameter int DEPTH = 17,
  parameter int NRES  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic [$clog2(DEPTH)-1:0]   tail_ptr,
  input logic                       qwr_en,
  input logic [255:0]               qwr_data,
  input logic                       irq,
  input logic                       ack_wr,
  input logic [NRES-1:0]            ack_mask,
  input logic [NRES-1:0]            res_busy
);
  localparam int PTR_W = $clog2(DEPTH);

  p_tail_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tail_ptr == (($past(tail_ptr) == PTR_W'(DEPTH-1))
                                 ? '0 : $past(tail_ptr) + PTR_W'(1))));

  p_write_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (qwr_en && irq));

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == ($clog2(DEPTH+1))'(DEPTH)) |-> !in_ready);

  p_vec_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    qwr_en |-> $onehot0(qwr_data[127:120]));

  p_zero_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qwr_en |-> (qwr_data[255:144] == '0));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((res_busy & $past(ack_mask & res_busy)) == '0));
endmodule

bind inbound_msg_queue imq_checker #(.DEPTH(DEPTH), .NRES(NRES)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .in_ready(in_ready),
  .occ(occ), .tail_ptr(tail_ptr), .qwr_en(qwr_en), .qwr_data(qwr_data),
  .irq(irq), .ack_wr(ack_wr), .ack_mask(ack_mask), .res_busy(res_busy)
);

// File: tb/tb_inbound_msg_queue.sv
module tb_inbound_msg_queue;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, in_valid, in_ready, pop, ack_wr, qwr_en, irq, irq_both;
  logic [127:0] in_hdr, in_pay;
  logic [7:0]   ack_mask, res_busy;
  logic [4:0]   qwr_addr, head_ptr, tail_ptr;
  logic [255:0] qwr_data;

  inbound_msg_queue dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_pay(in_pay), .pop(pop), .ack_wr(ack_wr),
    .ack_mask(ack_mask), .qwr_en(qwr_en), .qwr_addr(qwr_addr),
    .qwr_data(qwr_data), .irq(irq), .irq_both(irq_both),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .res_busy(res_busy)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] m_busy = '0;
  int m_head = 0, m_tail = 0, m_cnt = 0;

  // {payload seed, header seed, ack flag, both flag}
  localparam logic [65:0] TBL [6] = '{
    {32'h1357_9BDF, 32'h0400_0000, 1'b1, 1'b0},
    {32'hCAFE_F00D, 32'hFFFF_FFFF, 1'b0, 1'b1},
    {32'h0000_0001, 32'h8000_0001, 1'b1, 1'b1},
    {32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1, 1'b0},
    {32'hFFFF_0000, 32'h0000_FFFF, 1'b0, 1'b0},
    {32'h0F0F_F0F0, 32'h0123_4567, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_hdr(logic [31:0] s, bit a, bit b);
    logic [127:0] h;
    h = {4{s}};
    h[89] = a;
    h[101] = b;
    return h;
  endfunction

  function automatic logic [255:0] exp_entry(logic [127:0] h, logic [127:0] p,
                                             logic [7:0] v);
    logic [255:0] e;
    e = '0;
    e[95:0]    = p[95:0];
    e[119:96]  = h[81:58];
    e[127:120] = v;
    e[143:128] = h[56:41];
    return e;
  endfunction

  function automatic logic [7:0] low_free(logic [7:0] b);
    for (int i = 0; i < 8; i++) if (!b[i]) return 8'(1 << i);
    return 8'h00;
  endfunction

  task automatic push(input logic [127:0] h, input logic [127:0] p, input string tag);
    logic [7:0] v;
    @(negedge clk);
    in_hdr = h; in_pay = p; in_valid = 1'b1;
    #1;
    check(in_ready == 1'b1, {tag, " ready"}, in_ready, 1);
    v = h[89] ? low_free(m_busy) : 8'h00;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check(qwr_en && irq, {tag, " R5 R6 strobe"}, {qwr_en, irq}, 2'b11);
    check(qwr_addr == 5'(m_tail), {tag, " R5 addr"}, qwr_addr, m_tail);
    check(qwr_data == exp_entry(h, p, v), {tag, " R2 R3 R4 entry"}, qwr_data,
          exp_entry(h, p, v));
    check(irq_both == h[101], {tag, " R6 both"}, irq_both, h[101]);
    m_busy = m_busy | v;
    m_tail = (m_tail == 16) ? 0 : m_tail + 1;
    m_cnt++;
    check(tail_ptr == 5'(m_tail), {tag, " R5 tail"}, tail_ptr, m_tail);
    check(res_busy == m_busy, {tag, " R4 busy"}, res_busy, m_busy);
    @(posedge clk);
    #1;
    check(!qwr_en && !irq, {tag, " R6 single pulse"}, {qwr_en, irq}, 0);
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(posedge clk);
    #1;
    pop = 1'b0;
    if (m_cnt > 0) begin
      m_head = (m_head == 16) ? 0 : m_head + 1;
      m_cnt--;
    end
  endtask

  task automatic do_ack(input logic [7:0] m);
    @(negedge clk);
    ack_wr = 1'b1; ack_mask = m;
    @(posedge clk);
    #1;
    ack_wr = 1'b0; ack_mask = '0;
    m_busy = m_busy & ~m;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_hdr = '0; in_pay = '0;
    pop = 1'b0; ack_wr = 1'b0; ack_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(head_ptr == 0 && tail_ptr == 0, "R1 pointers", {head_ptr, tail_ptr}, 0);
    check(!qwr_en && !irq, "R1 strobes", {qwr_en, irq}, 0);
    check(res_busy == 0, "R1 busy", res_busy, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      push(mk_hdr(TBL[i][33:2], TBL[i][1], TBL[i][0]), {4{TBL[i][65:34]}},
           $sformatf("tbl%0d", i));
    end
    check(res_busy == 8'h0F, "R4 table busy", res_busy, 8'h0F);

    // R9: release 0 and 2, bit 7 is already free
    do_ack(8'h85);
    check(res_busy == 8'h0A, "R9 release", res_busy, 8'h0A);
    // R11: lowest freed first
    push(mk_hdr(32'h1111_2222, 1, 0), {4{32'h3333_4444}}, "R11 first");
    check(res_busy == 8'h0B, "R11 took 0", res_busy, 8'h0B);
    push(mk_hdr(32'h5555_6666, 1, 0), {4{32'h7777_8888}}, "R11 second");
    check(res_busy == 8'h0F, "R11 took 2", res_busy, 8'h0F);

    // drain, then R10 pop on empty
    for (int i = 0; i < 8; i++) do_pop();
    check(head_ptr == 5'(m_head), "R10 drained head", head_ptr, m_head);
    do_pop();
    check(head_ptr == 5'd8, "R10 empty pop", head_ptr, 8);

    // R5 wrap and R7 full, starting at tail 8
    for (int i = 0; i < 17; i++)
      push(mk_hdr(32'(i * 7919), 0, i[0]), {4{32'(i * 104729)}}, $sformatf("fill%0d", i));
    check(tail_ptr == 5'd8, "R5 wrapped tail", tail_ptr, 8);
    @(negedge clk);
    in_hdr = mk_hdr(32'h0, 0, 0); in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, "R7 full ready", in_ready, 0);
    @(posedge clk);
    #1;
    check(!qwr_en && tail_ptr == 5'd8, "R7 no write", {qwr_en, tail_ptr}, 8);
    in_valid = 1'b0;
    do_pop();
    #1;
    check(in_ready == 1'b1, "R7 room after pop", in_ready, 1);
    for (int i = 0; i < 16; i++) do_pop();
    check(head_ptr == tail_ptr, "R10 drained", head_ptr, tail_ptr);

    // R8 resource exhaustion
    do_ack(8'hFF);
    for (int i = 0; i < 8; i++)
      push(mk_hdr(32'hC0DE_0000 + 32'(i), 1, 0), {4{32'(i)}}, $sformatf("R8 fill%0d", i));
    check(res_busy == 8'hFF, "R8 all busy", res_busy, 8'hFF);
    @(negedge clk);
    in_hdr = mk_hdr(32'h2468_ACE0, 1, 0);
    #1;
    check(in_ready == 1'b0, "R8 ack msg refused", in_ready, 0);
    in_hdr = mk_hdr(32'h2468_ACE0, 0, 0);
    #1;
    check(in_ready == 1'b1, "R8 plain msg ready", in_ready, 1);
    push(mk_hdr(32'h2468_ACE0, 0, 1), {4{32'hDEAD_BEEF}}, "R8 plain");
    do_ack(8'h90);
    check(res_busy == 8'h6F, "R9 partial", res_busy, 8'h6F);
    push(mk_hdr(32'h0BAD_F00D, 1, 1), {4{32'h1234_5678}}, "R11 after mask");
    check(res_busy == 8'h7F, "R11 took 4", res_busy, 8'h7F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule